// File: doc/BRIEF.md
# Valid-Gated Pipeline Register Stage

This block is one register stage of a pipeline. Its data register takes a clock edge only when an enable is granted, and that enable comes from the valid flag of the entry arriving from upstream. A stall from downstream makes the stage hold the entry it already has. The stall is passed back upstream in the same cycle, but only while the stage holds a valid entry. An empty stage absorbs a new entry even while the downstream stall is raised.

A build-time mode sets how stalls affect the enable. With `GATE_VALID_ONLY`, a stall does not gate the clock. A valid upstream entry still clocks the register, and a recirculating mux keeps the held contents. With `GATE_VALID_AND_STALL`, stall cycles are gated as well. The stage brings out its clock enable. It also brings out a registered activity pulse, so that power accounting can count the edges the register really received.

The enable is modelled behaviourally as a flop enable, with no latch and no clock-gating cell. The valid flag is a single flop with a free-running clock.

Top module: `cg_pipe_stage`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `act_o` and `data_o` are 0, with no clock edge needed.
- R2: `stall_o` is high in the same cycle exactly when `stall_i` is high and `valid_o` is high.
- R3: In a cycle with `stall_o` high, `data_o` and `valid_o` keep their values across the next edge.
- R4: In a cycle with `stall_o` low, `valid_o` after the next edge equals `valid_i`.
- R5: In a cycle with `valid_i` high and `stall_o` low, `data_o` after the next edge equals `data_i`.
- R6: In a cycle with `valid_i` low, `data_o` keeps its value across the next edge.
- R7: In mode `GATE_VALID_ONLY`, `clk_en_o` equals `valid_i`, whether or not a stall is present.
- R8: In mode `GATE_VALID_AND_STALL`, `clk_en_o` is high exactly when `valid_i` is high and `stall_o` is low.
- R9: `act_o` is high in the cycle after each edge at which `clk_en_o` was high, and at no other time. Its total count over a run therefore equals the number of enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | DATA_W | Entry payload from upstream |
| valid_i | input | 1 | Upstream entry is valid |
| stall_i | input | 1 | Downstream cannot accept |
| data_o | output | DATA_W | Registered payload to downstream |
| valid_o | output | 1 | Registered entry valid |
| stall_o | output | 1 | Stall passed back to upstream |
| clk_en_o | output | 1 | Clock enable of the data register |
| act_o | output | 1 | One-cycle pulse after each enabled edge |

## Verification
The bench runs one instance in each mode on the same stimulus. It targets four corner cases:

- **Valid entry during a stall.** In the ungated mode the enable must stay high while the data must not move. A design without the recirculating mux would overwrite the held entry.
- **Stall into an empty stage.** The stall must not propagate and the new entry must be taken. A design that forwards the stall unconditionally would lock the pipe around bubbles.
- **Bubbles.** The payload must stay frozen while the valid flag drops. A design that gates the valid flop together with the data would replicate a stale entry.
- **Activity count in both modes.** A design that pulses on valid alone would over-count stall cycles in the gated mode.

// File: rtl/cg_stage_pkg.sv
package cg_stage_pkg;
  typedef enum logic {
    GATE_VALID_ONLY      = 1'b0,
    GATE_VALID_AND_STALL = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/cgs_gate_ctrl.sv
module cgs_gate_ctrl
  import cg_stage_pkg::*;
#(
  parameter gate_mode_e MODE = GATE_VALID_ONLY
) (
  input  logic valid_i,
  input  logic stall_i,
  input  logic valid_q_i,
  output logic hold_o,
  output logic load_o,
  output logic clk_en_o
);
  // an empty stage never holds, so bubbles are squeezed out
  assign hold_o = stall_i & valid_q_i;
  assign load_o = valid_i & ~hold_o;

  generate
    if (MODE == GATE_VALID_AND_STALL) begin : g_stall_gated
      assign clk_en_o = load_o;
    end else begin : g_valid_gated
      assign clk_en_o = valid_i;
    end
  endgenerate
endmodule

// File: rtl/cgs_data_reg.sv
module cgs_data_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  // enabled edge while holding recirculates the stored value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= '0;
    else if (clk_en_i) q_q <= load_i ? d_i : q_q;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cg_pipe_stage.sv
module cg_pipe_stage
  import cg_stage_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter gate_mode_e MODE   = GATE_VALID_ONLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              stall_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              stall_o,
  output logic              clk_en_o,
  output logic              act_o
);
  logic valid_q, act_q, hold, load, clk_en;

  cgs_gate_ctrl #(.MODE(MODE)) u_ctrl (
    .valid_i  (valid_i),
    .stall_i  (stall_i),
    .valid_q_i(valid_q),
    .hold_o   (hold),
    .load_o   (load),
    .clk_en_o (clk_en)
  );

  cgs_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clk_en_i(clk_en),
    .load_i  (load),
    .d_i     (data_i),
    .q_o     (data_o)
  );

  // valid flag and activity flop run on the free clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      if (!hold) valid_q <= valid_i;
      act_q <= clk_en;
    end
  end

  assign valid_o  = valid_q;
  assign stall_o  = hold;
  assign clk_en_o = clk_en;
  assign act_o    = act_q;
endmodule

// File: rtl/cg_pipe_stage_chk.sv
module cg_pipe_stage_chk
  import cg_stage_pkg::*;
#(
  parameter int         DATA_W = 32,
  parameter gate_mode_e MODE   = GATE_VALID_ONLY
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_i,
  input logic              stall_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              stall_o,
  input logic              clk_en_o,
  input logic              act_o
);
  AST_RST_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> !valid_o && !act_o); // R1
  AST_STALL_UP: assert property (@(posedge clk_i) disable iff (!rst_ni) stall_o |-> stall_i && valid_o); // R2
  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni) stall_o |=> $stable(data_o) && valid_o); // R3
  AST_VALID_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) !stall_o |=> valid_o == $past(valid_i)); // R4
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && !stall_o |=> data_o == $past(data_i)); // R5
  AST_BUBBLE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(data_o)); // R6
  AST_NO_EN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |-> !clk_en_o); // R7
  AST_ACT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) clk_en_o |=> act_o); // R9
  AST_ACT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni) !clk_en_o |=> !act_o); // R9

  generate
    if (MODE == GATE_VALID_AND_STALL) begin : g_sg
      AST_STALL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) stall_o |-> !clk_en_o); // R8
      AST_FREE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i && !stall_o |-> clk_en_o); // R8
    end else begin : g_vo
      AST_STALL_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |-> clk_en_o); // R7
    end
  endgenerate
endmodule

bind cg_pipe_stage cg_pipe_stage_chk #(.DATA_W(DATA_W), .MODE(MODE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_i  (data_i),
  .valid_i (valid_i),
  .stall_i (stall_i),
  .data_o  (data_o),
  .valid_o (valid_o),
  .stall_o (stall_o),
  .clk_en_o(clk_en_o),
  .act_o   (act_o)
);

// File: tb/cg_pipe_stage_tb.sv
`timescale 1ns/1ps
module cg_pipe_stage_tb;
  import cg_stage_pkg::*;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [W-1:0] d;
  logic v, s;
  logic [W-1:0] q_d [2];
  logic q_v [2], q_s [2], q_e [2], q_a [2];

  cg_pipe_stage #(.DATA_W(W), .MODE(GATE_VALID_ONLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d), .valid_i(v), .stall_i(s),
    .data_o(q_d[0]), .valid_o(q_v[0]), .stall_o(q_s[0]), .clk_en_o(q_e[0]), .act_o(q_a[0]));

  cg_pipe_stage #(.DATA_W(W), .MODE(GATE_VALID_AND_STALL)) u_dut_sg (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d), .valid_i(v), .stall_i(s),
    .data_o(q_d[1]), .valid_o(q_v[1]), .stall_o(q_s[1]), .clk_en_o(q_e[1]), .act_o(q_a[1]));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] m_d [2];
  logic m_v [2], m_a [2];
  int en_cnt [2], act_cnt [2];

  function automatic logic f_hold(logic st, logic vq);
    return st & vq;
  endfunction

  function automatic logic f_en(int m, logic vi, logic st, logic vq);
    return vi & ((m == 0) | ~f_hold(st, vq));
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_d[i] = '0; m_v[i] = 1'b0; m_a[i] = 1'b0;
    end
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < 2; i++) begin
      chk(q_d[i] === m_d[i], $sformatf("%s data m%0d", tag, i), 32'(q_d[i]), 32'(m_d[i]));
      chk(q_v[i] === m_v[i], $sformatf("%s valid m%0d", tag, i), 32'(q_v[i]), 32'(m_v[i]));
      chk(q_a[i] === m_a[i], $sformatf("R9 act m%0d", i), 32'(q_a[i]), 32'(m_a[i]));
    end
  endtask

  // entered and left at a falling edge
  task automatic step(logic vn, logic sn, logic [W-1:0] dn);
    logic h, e;
    v = vn; s = sn; d = dn;
    #2;
    for (int i = 0; i < 2; i++) begin
      h = f_hold(sn, m_v[i]);
      e = f_en(i, vn, sn, m_v[i]);
      chk(q_s[i] === h, $sformatf("R2 stall_o m%0d", i), 32'(q_s[i]), 32'(h));
      chk(q_e[i] === e, (i == 0) ? "R7 clk_en" : "R8 clk_en", 32'(q_e[i]), 32'(e));
      if (e) en_cnt[i]++;
      if (vn && !h) m_d[i] = dn;
      if (!h) m_v[i] = vn;
      m_a[i] = e;
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) if (q_a[i] === 1'b1) act_cnt[i]++;
    check_regs("R3_R4_R5_R6");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog R1..R9 act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; v = 1'b0; s = 1'b0; d = '0;
    model_reset();
    for (int i = 0; i < 2; i++) begin en_cnt[i] = 0; act_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    check_regs("R1 reset");
    rst_n = 1'b1;

    step(1'b1, 1'b0, 16'hA5A5); // R5 capture
    step(1'b1, 1'b1, 16'h1111); // R3 hold, R7 ungated enable
    step(1'b1, 1'b1, 16'h2222); // R3
    step(1'b0, 1'b0, 16'h3333); // R6 bubble, R4
    step(1'b0, 1'b1, 16'h4444); // R2 stall on empty
    step(1'b1, 1'b1, 16'h5555); // R2 empty stage absorbs
    step(1'b1, 1'b0, 16'h6666);
    step(1'b0, 1'b1, 16'h7777); // R8 gated stall

    for (int k = 0; k < 600; k++)
      step(($urandom % 4) != 0, ($urandom % 3) == 0, W'($urandom));

    // R1 mid-run asynchronous reset
    v = 1'b1; s = 1'b0; d = 16'hBEEF;
    rst_n = 1'b0;
    #2;
    model_reset();
    for (int i = 0; i < 2; i++) begin
      chk(q_v[i] === 1'b0, "R1 async valid", 32'(q_v[i]), 32'd0);
      chk(q_d[i] === '0, "R1 async data", 32'(q_d[i]), 32'd0);
    end
    @(negedge clk);
    check_regs("R1 held");
    rst_n = 1'b1;

    for (int k = 0; k < 300; k++)
      step(($urandom % 2) != 0, ($urandom % 2) == 0, W'($urandom));

    for (int i = 0; i < 2; i++)
      chk(act_cnt[i] == en_cnt[i], $sformatf("R9 total m%0d", i), 32'(act_cnt[i]), 32'(en_cnt[i]));
    finish_run();
  end
endmodule